// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers a parameterised set of external interrupt lines (sixteen by default) and presents them to one processor. Each line is sampled through its own configuration word, which holds a mask, a priority from 0 to 15, a vector number, a sense select (edge or level) and a polarity select. A destination word per source holds one bit per processor, and a source is delivered here only when the bit for this processor is set.

Software runs the controller through a 32-bit word-addressed register bus. The processor side has three registers. The task-priority register raises the floor below which interrupts are held off. Reading the acknowledge register returns the winning vector and moves that source into service. A write to the end-of-interrupt register retires the highest-priority source in service. When nothing qualifies, the acknowledge read returns a programmable spurious vector. Interrupts nest: a source can only pre-empt when its priority is above everything already in service.

Top module: `irqc_top`

## Requirements
- R1: After reset every source word reads 0x8000_0000 (masked, all other fields zero), every destination word reads 0, the task priority reads 15, the spurious vector reads 0xFF, irq_o is low and an acknowledge read returns the spurious vector. Word addresses: 0 feature, 1 global config, 2 spurious vector, 3 task priority, 4 acknowledge, 5 end-of-interrupt, 8+2i source i configuration, 9+2i source i destination.
- R2: Source configuration word layout: bit 31 mask, bit 30 activity (read-only), bit 23 polarity (1 = active high), bit 22 sense (1 = level), bits 19:16 priority, bits 7:0 vector. Written mask, polarity, sense, priority and vector read back unchanged, and a write to bit 30 has no effect.
- R3: The activity bit reads 1 while the source is pending or in service, and 0 otherwise. Masking does not hide a pending level source.
- R4: A source is delivered only if its priority is strictly above the task priority. At 15 nothing is delivered.
- R5: An acknowledge read returns the vector of the deliverable source with the highest priority, with ties going to the lowest source index, and puts that source in service.
- R6: When no source qualifies, the acknowledge read returns the spurious vector held in word 2 bits 7:0, which is writable.
- R7: Any write to the end-of-interrupt word retires the highest-priority in-service source. The word reads back 0.
- R8: A source is delivered only while bit 0 of its destination word (this processor) is set. A latched edge survives until the bit is set.
- R9: Writing 1 to bit 0 of the global config word makes that bit read 1 for one cycle. It then clears itself and returns all source words, destination words, pending state and in-service state to their reset values. Task priority and spurious vector are kept.
- R10: The feature word reads the last processor index in bits 15:8 and the last source index in bits 7:0 (0x0000_000F by default).
- R11: An edge source latches pending on the transition to its active level (rising when active high, falling when active low). The acknowledge clears the pending state, and the opposite transition latches nothing.
- R12: A level source is pending while its input is at the active level. After end-of-interrupt it is delivered again if the input is still active.
- R13: irq_o is high exactly when some deliverable source has a priority above both the task priority and the highest in-service priority.
- R14: A masked source is never delivered, and edges that arrive while it is masked are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | N_SRC | External interrupt lines |
| bus_addr | input | ADDR_W (6) | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; the acknowledge side effect happens on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is nesting with equal priorities: two sources share a priority while a third, higher one is already in service. The bench fires all three edges in the same cycle. It acknowledges the higher one, confirms that the equal pair cannot pre-empt it, then retires it and walks the tie in index order. It also confirms that while one of the pair is in service, its twin is held back. A reference model advances on every clock and predicts irq_o, so the bench catches any cycle where arbitration against task priority and in-service priority goes wrong, not just the points where it reads the acknowledge register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;
  localparam int DATA_W = 32;

  // word addresses on the register bus
  localparam int A_FEAT = 0;
  localparam int A_GCFG = 1;
  localparam int A_SPUR = 2;
  localparam int A_TASK = 3;
  localparam int A_ACK  = 4;
  localparam int A_EOI  = 5;
  localparam int A_SRC  = 8;

  // source configuration word bit positions
  localparam int B_MASK  = 31;
  localparam int B_POL   = 23;
  localparam int B_SENSE = 22;
  localparam int B_PRIO  = 16;

  typedef struct packed {
    logic              mask;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{mask: 1'b1, pol: 1'b0, sense: 1'b0, prio: '0, vec: '0};
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N = 16,
  parameter int W = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] prio_i,
  output logic                any_o,
  output logic [IW-1:0]       idx_o,
  output logic [W-1:0]        best_o
);
  // descending scan with >= lets the lowest index win a tie
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    best_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_i[i] && (!any_o || prio_i[i] >= best_o)) begin
        any_o  = 1'b1;
        idx_o  = IW'(i);
        best_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
#(
  parameter int N_CPU  = 1,
  parameter int CPU_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             irq_i,
  input  logic             vp_we,
  input  logic             dst_we,
  input  src_cfg_t         wcfg,
  input  logic [N_CPU-1:0] wdst,
  input  logic             ack_clr,
  input  logic             eoi_clr,
  output src_cfg_t         cfg_o,
  output logic [N_CPU-1:0] dst_o,
  output logic             pend_o,
  output logic             isr_o,
  output logic             elig_o
);
  src_cfg_t         cfg_q, cfg_d;
  logic [N_CPU-1:0] dst_q, dst_d;
  logic             samp_q, prev_q, pend_q, pend_d, isr_q, isr_d;
  logic             act, edge_set, cfg_en, dst_en;

  always_comb begin
    act      = cfg_q.pol ? irq_i : ~irq_i;
    edge_set = samp_q & ~prev_q;
    cfg_en   = soft_rst | vp_we;
    dst_en   = soft_rst | dst_we;
    cfg_d    = soft_rst ? CFG_RST : wcfg;
    dst_d    = soft_rst ? '0 : wdst;
    if (soft_rst || cfg_q.sense || cfg_q.mask) pend_d = 1'b0;
    else                                       pend_d = (pend_q & ~ack_clr) | edge_set;
    isr_d    = soft_rst ? 1'b0 : ((isr_q | ack_clr) & ~eoi_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      dst_q  <= '0;
      samp_q <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      isr_q  <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (dst_en) dst_q <= dst_d;
      samp_q <= act;
      prev_q <= samp_q;
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  assign pend_o = cfg_q.sense ? samp_q : pend_q;
  assign isr_o  = isr_q;
  assign cfg_o  = cfg_q;
  assign dst_o  = dst_q;
  assign elig_o = pend_o & ~cfg_q.mask & dst_q[CPU_ID] & ~isr_q;

  // R11: an acknowledged edge source drops its pending state unless a new edge arrives
  p_edge_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !cfg_q.sense && !edge_set) |=> !pend_q);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          N_SRC    = 16,
  parameter int          N_CPU    = 1,
  parameter int          CPU_ID   = 0,
  parameter logic [7:0]  SPUR_RST = 8'hFF,
  localparam int ADDR_W = $clog2(A_SRC + 2 * N_SRC),
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] FEAT_WORD = {16'b0, 8'(N_CPU - 1), 8'(N_SRC - 1)};

  logic [1:0]              rs_q;
  logic                    rst_int_n;
  logic                    rst_q, rst_d;
  logic [PRIO_W-1:0]       task_q;
  logic [VEC_W-1:0]        spur_q;
  logic                    task_en, spur_en, ack_rd, eoi_wr;
  src_cfg_t                wcfg;
  src_cfg_t                cfg_a [N_SRC];
  logic [N_CPU-1:0]        dst_a [N_SRC];
  logic [DATA_W-1:0]       vp_word [N_SRC];
  logic [N_SRC-1:0][PRIO_W-1:0] prio_a;
  logic [N_SRC-1:0]        vp_we, dst_we, ack_clr, eoi_clr, pend_b, isr_b, elig_b, dlv_v;
  logic                    dlv_any, isr_any;
  logic [IDX_W-1:0]        win_idx, isr_idx;
  logic [PRIO_W-1:0]       win_prio, isr_prio;
  logic [DATA_W-1:0]       src_rd, rd_d;
  logic                    unused_wbits;

  // reset: asserted asynchronously, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    ack_rd  = bus_rd && (bus_addr == ADDR_W'(A_ACK));
    eoi_wr  = bus_wr && (bus_addr == ADDR_W'(A_EOI));
    task_en = bus_wr && (bus_addr == ADDR_W'(A_TASK));
    spur_en = bus_wr && (bus_addr == ADDR_W'(A_SPUR));
    rst_d   = bus_wr && (bus_addr == ADDR_W'(A_GCFG)) && bus_wdata[0];
    wcfg    = '{mask: bus_wdata[B_MASK], pol: bus_wdata[B_POL], sense: bus_wdata[B_SENSE],
                prio: bus_wdata[B_PRIO +: PRIO_W], vec: bus_wdata[VEC_W-1:0]};
  end
  assign unused_wbits = ^{bus_wdata[30:24], bus_wdata[21:20], bus_wdata[15:8]};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rst_q  <= 1'b0;
      task_q <= '1;
      spur_q <= SPUR_RST;
    end else begin
      rst_q <= rst_d;
      if (task_en) task_q <= bus_wdata[PRIO_W-1:0];
      if (spur_en) spur_q <= bus_wdata[VEC_W-1:0];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign vp_we[g]  = bus_wr && (bus_addr == ADDR_W'(A_SRC + 2 * g));
    assign dst_we[g] = bus_wr && (bus_addr == ADDR_W'(A_SRC + 2 * g + 1));

    irqc_src #(.N_CPU(N_CPU), .CPU_ID(CPU_ID)) u_src (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .soft_rst (rst_q),
      .irq_i    (irq_i[g]),
      .vp_we    (vp_we[g]),
      .dst_we   (dst_we[g]),
      .wcfg     (wcfg),
      .wdst     (bus_wdata[N_CPU-1:0]),
      .ack_clr  (ack_clr[g]),
      .eoi_clr  (eoi_clr[g]),
      .cfg_o    (cfg_a[g]),
      .dst_o    (dst_a[g]),
      .pend_o   (pend_b[g]),
      .isr_o    (isr_b[g]),
      .elig_o   (elig_b[g])
    );

    assign prio_a[g]  = cfg_a[g].prio;
    assign dlv_v[g]   = elig_b[g] && (cfg_a[g].prio > task_q) && (cfg_a[g].prio > isr_prio);
    assign ack_clr[g] = ack_rd && dlv_any && (win_idx == IDX_W'(g));
    assign eoi_clr[g] = eoi_wr && isr_any && (isr_idx == IDX_W'(g));
    assign vp_word[g] = {cfg_a[g].mask, pend_b[g] | isr_b[g], 6'b0, cfg_a[g].pol,
                         cfg_a[g].sense, 2'b0, cfg_a[g].prio, 8'b0, cfg_a[g].vec};
  end

  irqc_pick #(.N(N_SRC), .W(PRIO_W)) u_pick_isr (
    .valid_i (isr_b), .prio_i (prio_a),
    .any_o (isr_any), .idx_o (isr_idx), .best_o (isr_prio)
  );

  irqc_pick #(.N(N_SRC), .W(PRIO_W)) u_pick_dlv (
    .valid_i (dlv_v), .prio_i (prio_a),
    .any_o (dlv_any), .idx_o (win_idx), .best_o (win_prio)
  );

  always_comb begin
    src_rd = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == ADDR_W'(A_SRC + 2 * i))     src_rd = vp_word[i];
      if (bus_addr == ADDR_W'(A_SRC + 2 * i + 1)) src_rd = DATA_W'(dst_a[i]);
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_FEAT): rd_d = FEAT_WORD;
      ADDR_W'(A_GCFG): rd_d = {31'b0, rst_q};
      ADDR_W'(A_SPUR): rd_d = DATA_W'(spur_q);
      ADDR_W'(A_TASK): rd_d = DATA_W'(task_q);
      ADDR_W'(A_ACK):  rd_d = dlv_any ? DATA_W'(cfg_a[win_idx].vec) : DATA_W'(spur_q);
      ADDR_W'(A_EOI):  rd_d = '0;
      default:         rd_d = src_rd;
    endcase
  end

  assign bus_rdata = rd_d;
  assign irq_o     = dlv_any;

  // R4: a task priority of 15 holds every source back
  p_task_block_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (task_q == '1) |-> !irq_o);
  // R13: a request always outranks the task priority
  p_irq_prio_r13: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (win_prio > task_q));
  // R5: the acknowledged winner is in service on the next cycle
  p_ack_isr_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_rd && dlv_any && !rst_q) |=> isr_b[$past(win_idx)]);
  // R7: end-of-interrupt retires exactly one in-service source
  p_eoi_drop_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eoi_wr && isr_any && !ack_rd && !rst_q) |=> ($countones(isr_b) + 1 == $past($countones(isr_b))));
  // R9: the soft reset bit clears itself
  p_rst_self_clear_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rst_q && !rst_d) |=> !rst_q);
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  import irqc_pkg::*;
  localparam int NS = 16;
  localparam int AW = $clog2(A_SRC + 2 * NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NS-1:0] irq_i = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_o;

  irqc_top #(.N_SRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  bit m_mask[NS], m_pol[NS], m_sense[NS], m_dst[NS], m_samp[NS], m_prev[NS], m_pend[NS], m_isr[NS];
  int m_prio[NS], m_vec[NS];
  int m_task, m_spur, m_cnt;
  bit m_grst;

  function automatic void m_src_default(int i);
    m_mask[i] = 1; m_pol[i] = 0; m_sense[i] = 0; m_prio[i] = 0; m_vec[i] = 0;
    m_dst[i] = 0; m_pend[i] = 0; m_isr[i] = 0;
  endfunction

  function automatic void m_reset_all();
    m_task = 15; m_spur = 255; m_grst = 0;
    for (int i = 0; i < NS; i++) begin
      m_src_default(i); m_samp[i] = 0; m_prev[i] = 0;
    end
  endfunction

  function automatic bit m_pending(int i);
    return m_sense[i] ? m_samp[i] : m_pend[i];
  endfunction

  function automatic int m_isr_top();
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (m_isr[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic int m_win();
    int e = m_isr_top();
    int ip = (e < 0) ? 0 : m_prio[e];
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (m_pending(i) && !m_mask[i] && m_dst[i] && !m_isr[i] &&
          m_prio[i] > m_task && m_prio[i] > ip && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic void m_step();
    int w = m_win();
    int e = m_isr_top();
    bit ackr = rd && int'(addr) == A_ACK;
    bit eoiw = wr && int'(addr) == A_EOI;
    bit g = m_grst;
    for (int i = 0; i < NS; i++) begin
      bit act = m_pol[i] ? irq_i[i] : !irq_i[i];
      bit es = m_samp[i] && !m_prev[i];
      bit ac = ackr && w == i;
      bit ec = eoiw && e == i;
      if (g || m_sense[i] || m_mask[i]) m_pend[i] = 0;
      else m_pend[i] = (m_pend[i] && !ac) || es;
      m_isr[i] = g ? 0 : ((m_isr[i] || ac) && !ec);
      m_prev[i] = m_samp[i];
      m_samp[i] = act;
      if (g) begin
        m_mask[i] = 1; m_pol[i] = 0; m_sense[i] = 0; m_prio[i] = 0; m_vec[i] = 0; m_dst[i] = 0;
      end else begin
        if (wr && int'(addr) == A_SRC + 2 * i) begin
          m_mask[i] = wdata[31]; m_pol[i] = wdata[23]; m_sense[i] = wdata[22];
          m_prio[i] = int'(wdata[19:16]); m_vec[i] = int'(wdata[7:0]);
        end
        if (wr && int'(addr) == A_SRC + 2 * i + 1) m_dst[i] = wdata[0];
      end
    end
    m_grst = wr && int'(addr) == A_GCFG && wdata[0];
    if (wr && int'(addr) == A_TASK) m_task = int'(wdata[3:0]);
    if (wr && int'(addr) == A_SPUR) m_spur = int'(wdata[7:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_cnt = 0; m_reset_all(); end
    else if (m_cnt < 2) begin m_cnt++; m_reset_all(); end
    else m_step();
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // R13: irq_o against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) chk("R13 irq_o", {31'b0, irq_o}, {31'b0, m_win() >= 0});
  end

  function automatic logic [31:0] vpw(bit m, bit a, bit p, bit s, int pr, int v);
    return (32'(m) << 31) | (32'(a) << 30) | (32'(p) << 23) | (32'(s) << 22) |
           (32'(pr) << 16) | 32'(v);
  endfunction

  task automatic bw(int a, logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rchk(string tag, int a, logic [31:0] exp);
    @(negedge clk); addr = AW'(a); rd = 1'b1;
    #2 chk(tag, rdata, exp);
    @(negedge clk); rd = 1'b0;
  endtask

  // acknowledge read: fixed expectation and model agreement
  task automatic ackx(string tag, int exp);
    @(negedge clk); addr = AW'(A_ACK); rd = 1'b1;
    #2 chk(tag, rdata, 32'(exp));
    chk({tag, " model"}, rdata, 32'(m_win() < 0 ? m_spur : m_vec[m_win()]));
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [NS-1:0] m);
    @(negedge clk); irq_i = irq_i | m;
    waitn(2); irq_i = irq_i & ~m;
    waitn(3);
  endtask

  task automatic cfg_src(int i, bit p, bit s, int pr, int v);
    bw(A_SRC + 2 * i, vpw(1, 0, p, s, pr, v));
    bw(A_SRC + 2 * i + 1, 32'd1);
    waitn(3);
    bw(A_SRC + 2 * i, vpw(0, 0, p, s, pr, v));
    waitn(2);
  endtask

  task automatic eoi();
    bw(A_EOI, 32'h1234);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(5);

    // reset state and feature word
    rchk("R10 feature", A_FEAT, 32'h0000_000F);
    rchk("R1 src0 word", A_SRC, 32'h8000_0000);
    rchk("R1 src0 dest", A_SRC + 1, 32'h0);
    rchk("R1 task", A_TASK, 32'd15);
    rchk("R1 spurious", A_SPUR, 32'hFF);
    rchk("R1 gcfg", A_GCFG, 32'h0);
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    ackx("R1 ack", 8'hFF);

    // R2 readback, activity bit read-only
    bw(A_SRC + 6, vpw(1, 1, 1, 0, 5, 8'h33));
    rchk("R2 readback", A_SRC + 6, vpw(1, 0, 1, 0, 5, 8'h33));
    bw(A_SRC + 7, 32'd1);
    rchk("R8 dest readback", A_SRC + 7, 32'd1);
    bw(A_TASK, 32'd0);
    bw(A_SRC + 6, vpw(0, 0, 1, 0, 5, 8'h33));
    waitn(2);

    // R11 rising edge on source 3
    pulse(16'h0008);
    rchk("R3 activity pending", A_SRC + 6, vpw(0, 1, 1, 0, 5, 8'h33));
    chk("R13 irq high", {31'b0, irq_o}, 32'h1);
    ackx("R5 ack src3", 8'h33);
    ackx("R6 none left", 8'hFF);
    rchk("R3 activity in service", A_SRC + 6, vpw(0, 1, 1, 0, 5, 8'h33));
    rchk("R7 eoi reads zero", A_EOI, 32'h0);
    eoi();
    rchk("R7 retired", A_SRC + 6, vpw(0, 0, 1, 0, 5, 8'h33));
    ackx("R11 cleared by ack", 8'hFF);

    // R11 active-low edge on source 4
    irq_i[4] = 1'b1;
    cfg_src(4, 0, 0, 3, 8'h44);
    @(negedge clk); irq_i[4] = 1'b0;
    waitn(4);
    ackx("R11 falling edge", 8'h44);
    eoi();
    @(negedge clk); irq_i[4] = 1'b1;
    waitn(4);
    ackx("R11 opposite edge ignored", 8'hFF);

    // R12 active-low level on source 5
    irq_i[5] = 1'b1;
    cfg_src(5, 0, 1, 7, 8'h55);
    @(negedge clk); irq_i[5] = 1'b0;
    waitn(3);
    ackx("R12 level ack", 8'h55);
    eoi();
    ackx("R12 still active", 8'h55);
    @(negedge clk); irq_i[5] = 1'b1;
    waitn(3);
    eoi();
    ackx("R12 released", 8'hFF);

    // R5 priority, tie and nesting
    cfg_src(1, 1, 0, 6, 8'h11);
    cfg_src(2, 1, 0, 6, 8'h22);
    cfg_src(6, 1, 0, 9, 8'h66);
    pulse(16'h0046);
    ackx("R5 highest first", 8'h66);
    chk("R13 held by in-service", {31'b0, irq_o}, 32'h0);
    ackx("R13 no preempt", 8'hFF);
    eoi();
    ackx("R5 tie lowest index", 8'h11);
    chk("R13 equal twin held", {31'b0, irq_o}, 32'h0);
    ackx("R13 equal twin", 8'hFF);
    eoi();
    ackx("R5 tie second", 8'h22);
    eoi();
    pulse(16'h0002);
    ackx("R5 nest low", 8'h11);
    pulse(16'h0040);
    ackx("R13 nest preempt", 8'h66);
    eoi();
    rchk("R7 lower still in service", A_SRC + 2, vpw(0, 1, 1, 0, 6, 8'h11));
    rchk("R7 higher retired", A_SRC + 12, vpw(0, 0, 1, 0, 9, 8'h66));
    ackx("R7 nothing pending", 8'hFF);
    eoi();
    rchk("R7 both retired", A_SRC + 2, vpw(0, 0, 1, 0, 6, 8'h11));

    // R4 task priority
    bw(A_TASK, 32'd15);
    pulse(16'h0040);
    ackx("R4 task 15", 8'hFF);
    bw(A_TASK, 32'd9);
    ackx("R4 equal priority", 8'hFF);
    bw(A_TASK, 32'd8);
    ackx("R4 above task", 8'h66);
    eoi();
    bw(A_TASK, 32'd0);

    // R14 mask
    bw(A_SRC + 10, vpw(1, 0, 0, 1, 7, 8'h55));
    @(negedge clk); irq_i[5] = 1'b0;
    waitn(3);
    ackx("R14 masked level", 8'hFF);
    rchk("R3 masked level active", A_SRC + 10, vpw(1, 1, 0, 1, 7, 8'h55));
    bw(A_SRC + 10, vpw(0, 0, 0, 1, 7, 8'h55));
    ackx("R14 unmasked level", 8'h55);
    @(negedge clk); irq_i[5] = 1'b1;
    waitn(3);
    eoi();
    bw(A_SRC + 6, vpw(1, 0, 1, 0, 5, 8'h33));
    pulse(16'h0008);
    bw(A_SRC + 6, vpw(0, 0, 1, 0, 5, 8'h33));
    waitn(2);
    ackx("R14 masked edge dropped", 8'hFF);

    // R8 destination
    bw(A_SRC + 7, 32'd0);
    pulse(16'h0008);
    ackx("R8 no destination", 8'hFF);
    bw(A_SRC + 7, 32'd1);
    ackx("R8 destination set", 8'h33);
    eoi();

    // R6 programmable spurious vector
    bw(A_SPUR, 32'hA5);
    rchk("R6 spurious readback", A_SPUR, 32'hA5);
    ackx("R6 spurious", 8'hA5);

    // R9 soft reset with a source in service
    pulse(16'h0002);
    ackx("R9 pre ack", 8'h11);
    @(negedge clk); addr = AW'(A_GCFG); wdata = 32'd1; wr = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b1;
    #2 chk("R9 bit set", rdata, 32'd1);
    @(negedge clk); #2 chk("R9 bit cleared", rdata, 32'd0);
    rd = 1'b0;
    rchk("R9 src1 default", A_SRC + 2, 32'h8000_0000);
    rchk("R9 src3 dest default", A_SRC + 7, 32'h0);
    rchk("R9 task kept", A_TASK, 32'd0);
    ackx("R9 in-service dropped", 8'hA5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule